// File: doc/BRIEF.md
# Sticky Masked Interrupt Register

This block gathers a vector of interrupt event lines into a sticky status vector. Once an event line is seen high, its status bit is set and stays set until the matching clear line is driven. Software or surrounding logic can read the status vector at any time. The vector shows every latched event, including events on lines that are currently disabled.

A mask vector selects which latched status bits may raise the single interrupt output. The interrupt output is a registered OR of the bitwise AND of status and mask. It can be dropped in two ways: clear every latched bit, or mask out every latched bit. The block only does collection and gating. Attaching it to a bus, and any priority or vectoring across several interrupt outputs, belongs to the surrounding design.

Top module: `irq_sticky_reg`

## Requirements
- R1: While the synchronous active-high reset `rst_i` is high at a rising clock edge, that edge clears every status bit and the interrupt output, even when event lines are high.
- R2: An event line `evt_i[k]` high at a clock edge makes `status_o[k]` 1 after that edge.
- R3: A set status bit stays 1 after its event line returns low, for as long as its clear line stays low.
- R4: `clr_i[k]` high with `evt_i[k]` low at an edge makes `status_o[k]` 0 after that edge, and leaves every other status bit unchanged.
- R5: When `evt_i[k]` and `clr_i[k]` are both high at the same edge, the event has priority and `status_o[k]` is 1 after that edge.
- R6: Status bits latch events whatever the value of `en_mask_i`. A bit whose mask is 0 is set and held, but does not raise `irq_o`.
- R7: `irq_o` after an edge equals the OR over all k of (`status_o[k]` AND `en_mask_i[k]`) as they stood before that edge. It therefore follows a mask change one clock later, and an event two clocks later.
- R8: `irq_o` returns to 0 one clock after all latched bits are cleared. It also returns to 0 one clock after the mask disables all latched bits.
- R9: The vector width is the parameter `WIDTH`, with a default of 32. Every bit position, including the top bit, behaves the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_i | input | WIDTH | Interrupt event lines, one per status bit |
| clr_i | input | WIDTH | Per-bit clear requests |
| en_mask_i | input | WIDTH | Per-bit enable for the interrupt output |
| status_o | output | WIDTH | Registered sticky status vector |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The main bench instance uses `WIDTH` = 12 and `OR_GROUP` = 4. This gives three equal reduction groups, so latched bits in different groups can be combined or masked off one group at a time, and the top bit of the last group is reachable. A second instance keeps the default parameters (32 bits, groups of 8) to check that bit 31 sets, holds and raises the output. The interrupt output is sampled on the exact clock after a mask change and after a clear, to check the one-clock lag.

// File: rtl/irq_sticky_pkg.sv
package irq_sticky_pkg;

  // number of reduction groups needed to cover a vector
  function automatic int unsigned group_count(input int unsigned width,
                                              input int unsigned group);
    return (width + group - 1) / group;
  endfunction

endpackage

// File: rtl/irq_status_bit.sv
module irq_status_bit (
  input  logic clk_i,
  input  logic rst_i,
  input  logic evt_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_d;

  // event wins over clear
  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (evt_i) q_d = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= 1'b0;
    else       q_o <= q_d;
  end

endmodule

// File: rtl/irq_trigger_reduce.sv
module irq_trigger_reduce #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned OR_GROUP = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_o
);

  import irq_sticky_pkg::*;

  localparam int unsigned NGROUP = group_count(WIDTH, OR_GROUP);
  localparam int unsigned PADW   = NGROUP * OR_GROUP;

  logic [PADW-1:0]   hit_pad;
  logic [NGROUP-1:0] grp_hit;

  generate
    if (PADW > WIDTH) begin : g_pad
      assign hit_pad = {{(PADW-WIDTH){1'b0}}, status_i & mask_i};
    end else begin : g_nopad
      assign hit_pad = status_i & mask_i;
    end
  endgenerate

  genvar g;
  generate
    for (g = 0; g < NGROUP; g++) begin : g_grp
      assign grp_hit[g] = |hit_pad[g*OR_GROUP +: OR_GROUP];
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_o <= 1'b0;
    else       irq_o <= |grp_hit;
  end

endmodule

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned OR_GROUP = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] evt_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic [WIDTH-1:0] en_mask_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] status_q;

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_bit
      irq_status_bit u_bit (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .evt_i (evt_i[k]),
        .clr_i (clr_i[k]),
        .q_o   (status_q[k])
      );
    end
  endgenerate

  irq_trigger_reduce #(
    .WIDTH    (WIDTH),
    .OR_GROUP (OR_GROUP)
  ) u_reduce (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .status_i (status_q),
    .mask_i   (en_mask_i),
    .irq_o    (irq_o)
  );

  assign status_o = status_q;

endmodule

// File: rtl/irq_sticky_chk.sv
module irq_sticky_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [WIDTH-1:0] evt_i,
  input logic [WIDTH-1:0] clr_i,
  input logic [WIDTH-1:0] en_mask_i,
  input logic [WIDTH-1:0] status_o,
  input logic             irq_o
);

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    rst_i |=> (status_o == '0) && !irq_o); // R1

  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((status_o & $past(evt_i)) == $past(evt_i))); // R5

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i))); // R3

  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((status_o & $past(clr_i & ~evt_i)) == '0)); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((status_o & ~$past(status_o | evt_i)) == '0)); // R2

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (irq_o == (|$past(status_o & en_mask_i)))); // R7

endmodule

bind irq_sticky_reg irq_sticky_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .evt_i     (evt_i),
  .clr_i     (clr_i),
  .en_mask_i (en_mask_i),
  .status_o  (status_o),
  .irq_o     (irq_o)
);

// File: tb/irq_sticky_reg_test.sv
module irq_sticky_reg_test;

  localparam int W = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  evt, clr, msk;
  logic [W-1:0]  status;
  logic          irq;
  logic [31:0]   evt32, clr32, msk32, status32;
  logic          irq32;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_sticky_reg #(.WIDTH(W), .OR_GROUP(4)) uut (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .clr_i(clr), .en_mask_i(msk),
    .status_o(status), .irq_o(irq)
  );

  irq_sticky_reg uut32 (
    .clk_i(clk), .rst_i(rst), .evt_i(evt32), .clr_i(clr32), .en_mask_i(msk32),
    .status_o(status32), .irq_o(irq32)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; evt = '1; clr = '0; msk = '1;
    evt32 = '1; clr32 = '0; msk32 = '1;
    tick(); tick();
    check("R1 status", {20'd0, status}, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    check("R1 status32", status32, 32'h0);
    rst = 1'b0; evt = '0; msk = '0; evt32 = '0; msk32 = '0;
    tick();
  endtask

  task automatic t_set_hold();
    evt = 12'h005;
    tick();
    check("R2 set", {20'd0, status}, 32'h005);
    evt = '0;
    tick();
    check("R3 hold", {20'd0, status}, 32'h005);
    tick();
    check("R6 masked no irq", {31'd0, irq}, 32'h0);
    check("R6 status kept", {20'd0, status}, 32'h005);
  endtask

  task automatic t_mask();
    msk = 12'h004;
    tick();
    check("R7 irq after mask", {31'd0, irq}, 32'h1);
    msk = 12'h0F0;
    tick();
    check("R8 mask out drops irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_clear();
    msk = 12'h001;
    tick();
    check("R7 irq bit0", {31'd0, irq}, 32'h1);
    clr = 12'h001;
    tick();
    clr = '0;
    check("R4 clear one", {20'd0, status}, 32'h004);
    check("R7 irq lags clear", {31'd0, irq}, 32'h1);
    tick();
    check("R8 irq drops after clear", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_collision();
    evt = 12'h800; clr = 12'h800;
    tick();
    evt = '0; clr = '0;
    check("R5 event wins", {20'd0, status}, 32'h804);
    msk = 12'h800;
    tick();
    check("R7 top bit irq", {31'd0, irq}, 32'h1);
    evt = 12'h040; clr = 12'h804; msk = 12'hFFF;
    tick();
    evt = '0; clr = '0;
    check("R4 clear all set", {20'd0, status}, 32'h040);
    check("R7 irq from old status", {31'd0, irq}, 32'h1);
    clr = 12'h040;
    tick();
    clr = '0;
    check("R4 empty", {20'd0, status}, 32'h0);
    tick();
    check("R8 all cleared", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_wide();
    evt32 = 32'h8000_0000;
    tick();
    evt32 = '0;
    check("R9 top bit set", status32, 32'h8000_0000);
    msk32 = 32'h8000_0000;
    tick();
    check("R9 top bit held", status32, 32'h8000_0000);
    tick();
    check("R9 irq wide", {31'd0, irq32}, 32'h1);
  endtask

  initial begin
    rst = 1'b1; evt = '0; clr = '0; msk = '0;
    evt32 = '0; clr32 = '0; msk32 = '0;
    tick();
    t_reset();
    t_set_hold();
    t_mask();
    t_clear();
    t_collision();
    t_wide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule